// File: doc/BRIEF.md
# Timer event status register

This block holds one sticky flag for each event a timer channel can raise: counter overflow, two compare matches and five captures. The timer core outside it owns the counter, the compare values and the capture logic. It sends the block only single-cycle event pulses, a level that says whether the timer is running, and one level per compare that says whether that compare value currently equals the counter.

Software sees two words on a small register port. The status word holds the flags, and writing 1 to a flag bit clears that flag. The enable word chooses which flags may raise an interrupt request. The block drives a per-flag request vector and a single combined request.

A compare flag can refuse a clear. While the timer is stopped and its compare value still equals the counter, a write-1 clear of that flag is dropped. The clear works again once the equality indication goes away, that is, once the compare value or the counter has changed.

Top module: `tmr_evt_status`

## Requirements
- R1: A one-cycle event pulse sets its flag at the next rising clock edge, whatever the enable word holds.
- R2: Writing 1 to a set flag at byte address 0x0C clears it at the next edge, and its request bit in `irq_vec` drops in the same cycle as the flag.
- R3: A 0 in a status write leaves that flag and its request unchanged.
- R4: A 1 written to a flag that is already clear leaves the status and every request unchanged.
- R5: When `tmr_run` is 0 and `cmp_eq[k]` is 1 in the cycle of the write, a write-1 clear of compare flag k is ignored. The same clear succeeds once `cmp_eq[k]` is 0.
- R6: A clear of a compare flag succeeds whenever the timer is running or its equality level is 0.
- R7: If an event pulse and a write-1 clear of the same flag fall in the same cycle, the flag stays set.
- R8: Status word layout: bit 0 is overflow, bits 1 and 2 are compares 0 and 1, and bits 3 to 7 are captures 0 to 4. Bits 31:8 read as zero.
- R9: After reset, every flag, every enable bit, `irq_vec` and `irq_any` are 0.
- R10: `irq_vec[i]` is 1 exactly when flag i and enable bit i are both 1, in the same cycle that both registers hold those values.
- R11: `irq_any` is the OR of `irq_vec` delayed by one clock cycle.
- R12: The enable word at byte address 0x10 is written and read back in bits 7:0, with bits 31:8 reading as zero. Writing it never changes a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovf_evt | input | 1 | Overflow event pulse |
| cmp_evt | input | 2 | Compare match event pulses |
| cap_evt | input | 5 | Capture event pulses |
| tmr_run | input | 1 | High while the timer counts |
| cmp_eq | input | 2 | High while each compare value equals the counter |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address for both read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational on `addr` |
| irq_vec | output | 8 | Per-flag interrupt requests |
| irq_any | output | 1 | Registered combined interrupt request |

## Verification
Every event is swept one at a time. For each one the bench checks the bit it lands on and runs writes of 0 and writes of 1 to clear bits against it. A wrong bit mapping would show up as a flag on the wrong bit, and a plain write-through register would either clear flags on 0 or set them on 1. All four combinations of run and equality are applied to both compare flags. A design that blocks the clear on equality alone would fail the running cases, and one that never releases the block would fail the retry. An event that coincides with a clear must leave the flag set, or the event is lost. A full sweep of the enable word then checks each request bit against its flag and checks that the combined request lags by exactly one cycle.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
    localparam int N_CMP    = 2;
    localparam int N_CAP    = 5;
    localparam int NUM_EVT  = 1 + N_CMP + N_CAP;
    localparam int OVF_BIT  = 0;
    localparam int CMP_BASE = OVF_BIT + 1;
    localparam int CAP_BASE = CMP_BASE + N_CMP;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

    typedef struct packed {
        evt_vec_t flags;
    } flag_state_t;

    typedef struct packed {
        evt_vec_t ena;
        logic     any;
    } irq_state_t;
endpackage

// File: rtl/tmr_evt_flag_bank.sv
module tmr_evt_flag_bank
    import tmr_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  evt_vec_t         evt_in,
    input  evt_vec_t         clr_req,
    input  logic             run,
    input  logic [N_CMP-1:0] cmp_eq,
    output evt_vec_t         flags
);
    flag_state_t state_d, state_q;
    evt_vec_t    hold_mask;
    evt_vec_t    clr_eff;

    // Only compare bits can be held; every other bit has a zero in the mask.
    always_comb begin
        hold_mask = '0;
        for (int k = 0; k < N_CMP; k++) begin
            hold_mask[CMP_BASE+k] = !run && cmp_eq[k];
        end
    end

    always_comb begin
        clr_eff       = clr_req & ~hold_mask;
        state_d       = state_q;
        state_d.flags = (state_q.flags & ~clr_eff) | evt_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign flags = state_q.flags;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit_chk
        // R1
        evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_in[i] |=> flags[i]);
        // R3
        idle_bit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt_in[i] && !clr_req[i]) |=> flags[i] == $past(flags[i]));
        // R7
        set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_in[i] && clr_req[i]) |=> flags[i]);
    end

    for (genvar k = 0; k < N_CMP; k++) begin : g_cmp_chk
        // R5
        stopped_match_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req[CMP_BASE+k] && !run && cmp_eq[k])
            |=> flags[CMP_BASE+k] == ($past(flags[CMP_BASE+k]) | $past(evt_in[CMP_BASE+k])));
        // R6
        cmp_clear_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req[CMP_BASE+k] && !evt_in[CMP_BASE+k] && (run || !cmp_eq[k]))
            |=> !flags[CMP_BASE+k]);
    end

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_plain_chk
        if (i < CMP_BASE || i >= CAP_BASE) begin : g_plain
            // R2
            plain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_req[i] && !evt_in[i]) |=> !flags[i]);
        end
    end
endmodule

// File: rtl/tmr_evt_irq.sv
module tmr_evt_irq
    import tmr_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ena_wr,
    input  evt_vec_t ena_wdata,
    input  evt_vec_t flags,
    output evt_vec_t ena,
    output evt_vec_t irq_vec,
    output logic     irq_any
);
    irq_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.any = |(flags & state_q.ena);
        if (ena_wr) state_d.ena = ena_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ena     = state_q.ena;
    assign irq_vec = flags & state_q.ena;
    assign irq_any = state_q.any;

    // R11
    any_lags_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_any == $past(|irq_vec));
    // R12
    ena_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ena_wr |=> ena == $past(ena_wdata));
endmodule

// File: rtl/tmr_evt_status.sv
module tmr_evt_status
    import tmr_evt_pkg::*;
#(
    parameter int              DATA_W    = 32,
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0C,
    parameter logic [ADDR_W-1:0] ENA_ADDR  = 8'h10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ovf_evt,
    input  logic [N_CMP-1:0]    cmp_evt,
    input  logic [N_CAP-1:0]    cap_evt,
    input  logic                tmr_run,
    input  logic [N_CMP-1:0]    cmp_eq,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NUM_EVT-1:0]  irq_vec,
    output logic                irq_any
);
    evt_vec_t evt_all;
    evt_vec_t clr_req;
    evt_vec_t flags;
    evt_vec_t ena;
    logic     stat_hit;
    logic     ena_hit;
    logic     unused_wdata_hi;

    assign evt_all[OVF_BIT]                   = ovf_evt;
    assign evt_all[CAP_BASE-1:CMP_BASE]       = cmp_evt;
    assign evt_all[NUM_EVT-1:CAP_BASE]        = cap_evt;

    assign stat_hit        = addr == STAT_ADDR;
    assign ena_hit         = addr == ENA_ADDR;
    assign clr_req         = (wr_en && stat_hit) ? wr_data[NUM_EVT-1:0] : '0;
    assign unused_wdata_hi = ^wr_data[DATA_W-1:NUM_EVT];

    tmr_evt_flag_bank u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_in  (evt_all),
        .clr_req (clr_req),
        .run     (tmr_run),
        .cmp_eq  (cmp_eq),
        .flags   (flags)
    );

    tmr_evt_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ena_wr    (wr_en && ena_hit),
        .ena_wdata (wr_data[NUM_EVT-1:0]),
        .flags     (flags),
        .ena       (ena),
        .irq_vec   (irq_vec),
        .irq_any   (irq_any)
    );

    always_comb begin
        rd_data = '0;
        if (stat_hit)     rd_data[NUM_EVT-1:0] = flags;
        else if (ena_hit) rd_data[NUM_EVT-1:0] = ena;
    end

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:NUM_EVT] == '0);
    // R12
    ena_write_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ena_hit && evt_all == '0) |=> flags == $past(flags));
endmodule

// File: tb/tmr_evt_status_test.sv
module tmr_evt_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ovf_evt = 1'b0;
    logic [1:0]  cmp_evt = '0;
    logic [4:0]  cap_evt = '0;
    logic        tmr_run = 1'b1;
    logic [1:0]  cmp_eq = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h0C;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  irq_vec;
    logic        irq_any;

    int checks = 0;
    int fails  = 0;

    localparam logic [7:0] STAT = 8'h0C;
    localparam logic [7:0] ENA  = 8'h10;

    always #10 clk = ~clk;

    tmr_evt_status uut (
        .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt),
        .cap_evt(cap_evt), .tmr_run(tmr_run), .cmp_eq(cmp_eq), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_vec(irq_vec),
        .irq_any(irq_any)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive_evt(input logic [7:0] v);
        ovf_evt = v[0];
        cmp_evt = v[2:1];
        cap_evt = v[7:3];
    endtask

    task automatic pulse(input logic [7:0] v);
        drive_evt(v);
        @(negedge clk);
        drive_evt(8'h00);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [7:0] ev);
        wr_en = 1'b1; addr = a; wr_data = d; drive_evt(ev);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; drive_evt(8'h00);
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        #1;
        chk(rd_data, {24'h0, exp}, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_chk(STAT, 8'h00, "R9 status reset");
        read_chk(ENA, 8'h00, "R9 enable reset");
        chk(irq_vec, 0, "R9 irq_vec reset");
        chk(irq_any, 0, "R9 irq_any reset");

        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            b = 8'(1 << i);
            pulse(b);
            read_chk(STAT, b, "R1 R8 event sets its bit");
            chk(irq_vec, 0, "R1 flag set with enables off");
            do_write(STAT, {24'h0, ~b}, 8'h00);
            read_chk(STAT, b, "R3 R4 zero and unset-bit writes ignored");
            chk(irq_vec, 0, "R4 no request from unset-bit write");
            do_write(ENA, {24'h0, b}, 8'h00);
            chk(irq_vec, b, "R10 request follows flag and enable");
            chk(irq_any, 0, "R11 combined request not yet");
            @(negedge clk);
            chk(irq_any, 1, "R11 combined request one cycle later");
            do_write(STAT, {24'h0, b}, 8'h00);
            read_chk(STAT, 8'h00, "R2 write one clears");
            chk(irq_vec, 0, "R2 request drops with flag");
            @(negedge clk);
            chk(irq_any, 0, "R11 combined request drops");
            do_write(ENA, 32'h0, 8'h00);
        end

        for (int k = 0; k < 2; k++) begin
            for (int c = 0; c < 4; c++) begin
                logic [7:0] b;
                logic blk;
                b = 8'(2 << k);
                pulse(b);
                tmr_run = c[0];
                cmp_eq = '0;
                cmp_eq[k] = c[1];
                blk = !c[0] && c[1];
                do_write(STAT, {24'h0, b}, 8'h00);
                if (blk) begin
                    read_chk(STAT, b, "R5 clear held while stopped at match");
                    cmp_eq = '0;
                    do_write(STAT, {24'h0, b}, 8'h00);
                    read_chk(STAT, 8'h00, "R5 clear after match ends");
                end else begin
                    read_chk(STAT, 8'h00, "R6 clear allowed");
                end
                tmr_run = 1'b1;
                cmp_eq = '0;
            end
        end

        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            b = 8'(1 << i);
            pulse(b);
            do_write(STAT, {24'h0, b}, b);
            read_chk(STAT, b, "R7 event beats clear");
            do_write(STAT, {24'h0, b}, 8'h00);
            read_chk(STAT, 8'h00, "R7 later clear works");
        end

        pulse(8'hFF);
        for (int e = 0; e < 256; e++) begin
            do_write(ENA, 32'(e) | 32'hFFFF_FF00, 8'h00);
            chk(irq_vec, 32'(e), "R10 enable sweep");
            read_chk(ENA, 8'(e), "R12 enable readback");
            @(negedge clk);
            chk(irq_any, (e != 0) ? 1 : 0, "R11 combined sweep");
        end
        read_chk(STAT, 8'hFF, "R12 enable writes leave flags");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule